// File: doc/BRIEF.md
# Configuration Status Monitor Port

This block watches the status lines that a programmable fabric drives while it is being configured, and turns them into levels that software can read and into a single interrupt. The low four of its twelve inputs carry fixed meanings: bit 0 is the active-low status line, bit 1 is configuration done, bit 2 is initialization done and bit 3 is the CRC error flag. The remaining eight bits are general-purpose monitor inputs. Each input can optionally be passed through a multi-flop synchronizer before it is used.

Every bit can be set up to raise interrupt status on a level or on an edge, with either polarity. Level bits follow the input. Edge bits latch and hold until software clears them through a write-one-to-clear register. The raw status is qualified by an enable and a mask, and the OR of the qualified bits drives the registered interrupt output. A separate registered ready output goes high only after initialization done has been seen high on two consecutive samples, so a single-cycle glitch cannot indicate readiness.

Software uses a simple word-indexed register port. Writes take effect on the clock edge, and read data is registered, arriving one cycle after the address is presented. The word map is: 0 input levels (read only), 1 raw status (read only), 2 qualified status (read only), 3 clear (write only, reads 0), 4 enable, 5 mask, 6 type, 7 polarity, 8 synchronizer enable (bit 0). All other offsets read 0.

Top module: `cmon_port`

## Requirements
- R1: While reset is asserted, enable, mask, type and polarity clear to 0, the synchronizer enable bit sets to 1, raw status clears, and `irq_o` and `fab_ready_o` are 0.
- R2: Word 0 returns the current sampled level of each input, with bit 0 the active-low status line, bit 1 configuration done, bit 2 initialization done and bit 3 CRC error.
- R3: With word 8 bit 0 set, an input change reaches the read path and status logic after two register stages. With bit 0 clear, the input is used in the same cycle.
- R4: A bit with type 0 (level) has a raw status equal to the input when its polarity bit is 1 and to the inverted input when its polarity bit is 0, updated every cycle.
- R5: A bit with type 1 (edge) sets its raw status on a rising input when its polarity bit is 1 and on a falling input when it is 0. It then holds at 1 until cleared.
- R6: Writing word 3 clears the edge-type raw bits whose write-data bit is 1. It leaves the other edge bits and all level bits unaffected, and word 3 reads 0.
- R7: If an edge event and a clear of the same bit fall on the same clock edge, the raw bit ends up set.
- R8: Word 2 equals raw AND enable AND NOT mask. `irq_o` is the OR of word 2 and follows it one cycle later.
- R9: `fab_ready_o` is 1 only after initialization done (bit 2) has been sampled high on two consecutive cycles. A one-cycle high pulse never raises it.
- R10: Read data appears one cycle after the address. Writes to the read-only words 0, 1 and 2 change nothing, and unused offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| mon_pins_i | input | MON_W | Fabric status and monitor inputs |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 4 | Register word index |
| cfg_wdata_i | input | MON_W | Register write data |
| cfg_rdata_o | output | MON_W | Registered read data |
| irq_o | output | 1 | Combined interrupt, registered |
| fab_ready_o | output | 1 | Initialization done seen high twice in a row |

## Verification
The cycle that matters most is the one where an edge on an input and a software clear of the same raw bit land on the same clock edge. The bench makes this happen by raising the rising-edge input at the same falling clock edge on which it presents the clear write. It then reads raw status and expects the bit to still be set. A second case has a clear arriving while a level-type bit is active, and the bench checks that the level bit survives while a pending edge bit in the same write is removed.

// File: rtl/cmon_pkg.sv
package cmon_pkg;

  localparam int unsigned CMON_AW = 4;

  typedef enum logic [CMON_AW-1:0] {
    OFS_EXT   = 4'd0,
    OFS_RAW   = 4'd1,
    OFS_MSTAT = 4'd2,
    OFS_CLR   = 4'd3,
    OFS_IEN   = 4'd4,
    OFS_MASK  = 4'd5,
    OFS_TYPE  = 4'd6,
    OFS_POL   = 4'd7,
    OFS_SYNC  = 4'd8
  } cmon_ofs_e;

  localparam int unsigned BIT_STATUS_N  = 0;
  localparam int unsigned BIT_CFG_DONE  = 1;
  localparam int unsigned BIT_INIT_DONE = 2;
  localparam int unsigned BIT_CRC_ERR   = 3;

endpackage

// File: rtl/cmon_sync.sv
module cmon_sync #(
  parameter int unsigned W      = 12,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i) begin
        if (rst_i) stg_q[g] <= '0;
        else       stg_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i) begin
        if (rst_i) stg_q[g] <= '0;
        else       stg_q[g] <= stg_q[g-1];
      end
    end
  end

  // bypass selects the raw input when synchronization is off
  assign q_o = en_i ? stg_q[STAGES-1] : d_i;

endmodule

// File: rtl/cmon_detect.sv
module cmon_detect #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] type_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] prev_o
);

  logic [W-1:0] raw_q;
  logic [W-1:0] prev_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic evt;
    logic active;

    assign active = ~(lvl_i[i] ^ pol_i[i]);
    assign evt    = pol_i[i] ? (lvl_i[i] & ~prev_q[i]) : (~lvl_i[i] & prev_q[i]);

    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        raw_q[i]  <= 1'b0;
        prev_q[i] <= 1'b0;
      end else begin
        prev_q[i] <= lvl_i[i];
        if (!type_i[i])    raw_q[i] <= active;
        else if (evt)      raw_q[i] <= 1'b1;   // a new event beats a clear
        else if (clr_i[i]) raw_q[i] <= 1'b0;
      end
    end
  end

  assign raw_o  = raw_q;
  assign prev_o = prev_q;

endmodule

// File: rtl/cmon_regs.sv
module cmon_regs
  import cmon_pkg::*;
#(
  parameter int unsigned W        = 12,
  parameter logic        SYNC_RST = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               wr_i,
  input  logic [CMON_AW-1:0] addr_i,
  input  logic [W-1:0]       wdata_i,
  input  logic [W-1:0]       ext_i,
  input  logic [W-1:0]       raw_i,
  output logic [W-1:0]       ien_o,
  output logic [W-1:0]       mask_o,
  output logic [W-1:0]       type_o,
  output logic [W-1:0]       pol_o,
  output logic               sync_o,
  output logic [W-1:0]       clr_o,
  output logic [W-1:0]       mstat_o,
  output logic [W-1:0]       rdata_o
);

  logic [W-1:0] ien_q, mask_q, type_q, pol_q, rdata_q;
  logic         sync_q;
  cmon_ofs_e    ofs;

  assign ofs = cmon_ofs_e'(addr_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ien_q  <= '0;
      mask_q <= '0;
      type_q <= '0;
      pol_q  <= '0;
      sync_q <= SYNC_RST;
    end else if (wr_i) begin
      case (ofs)
        OFS_IEN:  ien_q  <= wdata_i;
        OFS_MASK: mask_q <= wdata_i;
        OFS_TYPE: type_q <= wdata_i;
        OFS_POL:  pol_q  <= wdata_i;
        OFS_SYNC: sync_q <= wdata_i[0];
        default:  ;
      endcase
    end
  end

  assign clr_o   = (wr_i && ofs == OFS_CLR) ? wdata_i : '0;
  assign mstat_o = raw_i & ien_q & ~mask_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rdata_q <= '0;
    end else begin
      case (ofs)
        OFS_EXT:   rdata_q <= ext_i;
        OFS_RAW:   rdata_q <= raw_i;
        OFS_MSTAT: rdata_q <= mstat_o;
        OFS_IEN:   rdata_q <= ien_q;
        OFS_MASK:  rdata_q <= mask_q;
        OFS_TYPE:  rdata_q <= type_q;
        OFS_POL:   rdata_q <= pol_q;
        OFS_SYNC:  rdata_q <= {{(W-1){1'b0}}, sync_q};
        default:   rdata_q <= '0;
      endcase
    end
  end

  assign ien_o   = ien_q;
  assign mask_o  = mask_q;
  assign type_o  = type_q;
  assign pol_o   = pol_q;
  assign sync_o  = sync_q;
  assign rdata_o = rdata_q;

endmodule

// File: rtl/cmon_port.sv
module cmon_port
  import cmon_pkg::*;
#(
  parameter int unsigned MON_W       = 12,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic        SYNC_RST    = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [MON_W-1:0]   mon_pins_i,
  input  logic               cfg_wr_i,
  input  logic [CMON_AW-1:0] cfg_addr_i,
  input  logic [MON_W-1:0]   cfg_wdata_i,
  output logic [MON_W-1:0]   cfg_rdata_o,
  output logic               irq_o,
  output logic               fab_ready_o
);

  logic [MON_W-1:0] mon_sel, raw, prev;
  logic [MON_W-1:0] ien, mask, typ, pol, clr, mstat;
  logic             sync_en;
  logic             irq_q, ready_q;

  cmon_sync #(.W(MON_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .en_i  (sync_en),
    .d_i   (mon_pins_i),
    .q_o   (mon_sel)
  );

  cmon_detect #(.W(MON_W)) u_detect (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .lvl_i  (mon_sel),
    .type_i (typ),
    .pol_i  (pol),
    .clr_i  (clr),
    .raw_o  (raw),
    .prev_o (prev)
  );

  cmon_regs #(.W(MON_W), .SYNC_RST(SYNC_RST)) u_regs (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .wr_i    (cfg_wr_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .ext_i   (mon_sel),
    .raw_i   (raw),
    .ien_o   (ien),
    .mask_o  (mask),
    .type_o  (typ),
    .pol_o   (pol),
    .sync_o  (sync_en),
    .clr_o   (clr),
    .mstat_o (mstat),
    .rdata_o (cfg_rdata_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      irq_q   <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      irq_q   <= |mstat;
      ready_q <= mon_sel[BIT_INIT_DONE] & prev[BIT_INIT_DONE];
    end
  end

  assign irq_o       = irq_q;
  assign fab_ready_o = ready_q;

endmodule

// File: rtl/cmon_port_chk.sv
module cmon_port_chk
  import cmon_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input logic         clk_i,
  input logic         rst_i,
  input logic [W-1:0] sel_i,
  input logic [W-1:0] raw_i,
  input logic [W-1:0] type_i,
  input logic [W-1:0] pol_i,
  input logic [W-1:0] clr_i,
  input logic [W-1:0] mstat_i,
  input logic         irq_i,
  input logic         ready_i
);

  logic [1:0] age_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)              age_q <= 2'd0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    rst_i |=> (!irq_i && !ready_i && raw_i == '0));

  assert_level_follow_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (age_q != 2'd0) |-> (((raw_i ^ ~($past(sel_i) ^ $past(pol_i))) & ~$past(type_i)) == '0));

  assert_edge_hold_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (age_q != 2'd0) |-> (($past(raw_i) & $past(type_i) & ~$past(clr_i) & ~raw_i) == '0));

  assert_irq_follow_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (age_q != 2'd0) |-> (irq_i == $past(|mstat_i)));

  assert_ready_twice_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (age_q == 2'd2 && ready_i) |-> ($past(sel_i[BIT_INIT_DONE]) && $past(sel_i[BIT_INIT_DONE], 2)));

endmodule

bind cmon_port cmon_port_chk #(.W(MON_W)) u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .sel_i   (mon_sel),
  .raw_i   (raw),
  .type_i  (typ),
  .pol_i   (pol),
  .clr_i   (clr),
  .mstat_i (mstat),
  .irq_i   (irq_o),
  .ready_i (fab_ready_o)
);

// File: tb/cmon_port_bench.sv
module cmon_port_bench;

  localparam int unsigned W = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] pins = '0;
  logic         wr = 1'b0;
  logic [3:0]   addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic         irq, ready;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  cmon_port u_cmon_port (
    .clk_i       (clk),
    .rst_i       (rst),
    .mon_pins_i  (pins),
    .cfg_wr_i    (wr),
    .cfg_addr_i  (addr),
    .cfg_wdata_i (wdata),
    .cfg_rdata_o (rdata),
    .irq_o       (irq),
    .fab_ready_o (ready)
  );

  // {pins, polarity, expected raw} for level-type bits
  localparam logic [35:0] VEC [6] = '{
    {12'h000, 12'hFFF, 12'h000},
    {12'hA5C, 12'hFFF, 12'hA5C},
    {12'hA5C, 12'h000, 12'h5A3},
    {12'h123, 12'h0F0, 12'hE2C},
    {12'hFFF, 12'h000, 12'h000},
    {12'h00F, 12'h00F, 12'hFFF}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [W-1:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [W-1:0] d);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic expect_reg(input logic [3:0] a, input logic [W-1:0] e, input string tag);
    logic [W-1:0] v;
    rd_reg(a, v);
    check(v == e, tag, int'(v), int'(e));
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    idle(3);
    rst = 1'b0;
    // R1: reset values
    check(irq == 1'b0, "R1 irq", int'(irq), 0);
    check(ready == 1'b0, "R1 ready", int'(ready), 0);
    expect_reg(4'd4, 12'h000, "R1 enable");
    expect_reg(4'd5, 12'h000, "R1 mask");
    expect_reg(4'd6, 12'h000, "R1 type");
    expect_reg(4'd7, 12'h000, "R1 polarity");
    expect_reg(4'd8, 12'h001, "R1 sync");
    // R4: default polarity 0, level type, pins low -> all active
    expect_reg(4'd1, 12'hFFF, "R4 default raw");
    expect_reg(4'd2, 12'h000, "R8 mstat disabled");

    // R3: synchronizer on, two stages
    pins = 12'h001;
    rd_reg(4'd0, v); check(v == 12'h000, "R3 sync read1", int'(v), 0);
    rd_reg(4'd0, v); check(v == 12'h000, "R3 sync read2", int'(v), 0);
    rd_reg(4'd0, v); check(v == 12'h001, "R3 sync read3", int'(v), 1);
    wr_reg(4'd8, 12'h000);
    pins = 12'h000;
    rd_reg(4'd0, v); check(v == 12'h000, "R3 bypass", int'(v), 0);
    pins = 12'h004;
    rd_reg(4'd0, v); check(v == 12'h004, "R2 init done bit", int'(v), 4);

    // R4 / R2: table of level patterns
    for (int k = 0; k < 6; k++) begin
      wr_reg(4'd7, VEC[k][23:12]);
      pins = VEC[k][35:24];
      idle(1);
      expect_reg(4'd1, VEC[k][11:0], "R4 level table");
      expect_reg(4'd0, VEC[k][35:24], "R2 level table");
    end

    // edge setup: bit1 rising, bit3 falling, rest level active-high
    pins = '0;
    idle(2);
    wr_reg(4'd7, 12'hFF7);
    wr_reg(4'd6, 12'h00A);
    wr_reg(4'd4, 12'hFFF);
    wr_reg(4'd5, 12'h000);
    wr_reg(4'd3, 12'hFFF);
    idle(2);
    expect_reg(4'd1, 12'h000, "R6 cleared start");
    check(irq == 1'b0, "R8 irq idle", int'(irq), 0);

    pins[1] = 1'b1;
    @(negedge clk);
    check(irq == 1'b0, "R8 irq latency", int'(irq), 0);
    @(negedge clk);
    check(irq == 1'b1, "R8 irq raised", int'(irq), 1);
    pins[1] = 1'b0;
    idle(1);
    expect_reg(4'd1, 12'h002, "R5 rising held");
    pins[3] = 1'b1;
    idle(1);
    expect_reg(4'd1, 12'h002, "R5 wrong edge ignored");
    pins[3] = 1'b0;
    idle(1);
    expect_reg(4'd1, 12'h00A, "R5 falling latched");

    wr_reg(4'd3, 12'h002);
    expect_reg(4'd1, 12'h008, "R6 partial clear");
    expect_reg(4'd3, 12'h000, "R6 clear reads zero");
    pins[0] = 1'b1;
    idle(1);
    wr_reg(4'd3, 12'hFFF);
    expect_reg(4'd1, 12'h001, "R6 level kept edge cleared");

    // R7: event and clear on the same edge
    pins[1] = 1'b1;
    wr_reg(4'd3, 12'h002);
    expect_reg(4'd1, 12'h003, "R7 set wins");

    // R8: qualification
    wr_reg(4'd4, 12'h001);
    expect_reg(4'd2, 12'h001, "R8 enabled bit");
    @(negedge clk);
    check(irq == 1'b1, "R8 irq enabled", int'(irq), 1);
    wr_reg(4'd5, 12'h001);
    expect_reg(4'd2, 12'h000, "R8 masked");
    @(negedge clk);
    check(irq == 1'b0, "R8 irq masked", int'(irq), 0);
    wr_reg(4'd5, 12'h000);
    wr_reg(4'd4, 12'h000);
    expect_reg(4'd2, 12'h000, "R8 disabled");

    // R9: readiness filter
    pins = 12'h002;
    idle(2);
    pins[2] = 1'b1;
    @(negedge clk);
    pins[2] = 1'b0;
    check(ready == 1'b0, "R9 pulse a", int'(ready), 0);
    @(negedge clk);
    check(ready == 1'b0, "R9 pulse b", int'(ready), 0);
    @(negedge clk);
    check(ready == 1'b0, "R9 pulse c", int'(ready), 0);
    pins[2] = 1'b1;
    @(negedge clk);
    check(ready == 1'b0, "R9 first sample", int'(ready), 0);
    @(negedge clk);
    check(ready == 1'b1, "R9 second sample", int'(ready), 1);

    // R10: read-only words and unused offsets
    wr_reg(4'd1, 12'hFFF);
    expect_reg(4'd1, 12'h006, "R10 raw write ignored");
    wr_reg(4'd2, 12'hFFF);
    expect_reg(4'd2, 12'h000, "R10 mstat write ignored");
    wr_reg(4'd0, 12'hFFF);
    expect_reg(4'd0, 12'h006, "R10 ext write ignored");
    expect_reg(4'd15, 12'h000, "R10 unused offset");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule